// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Unit

This unit holds the status state of a small serial flash slave and decides which write-type requests may proceed. An SPI front end decodes commands and hands it single-cycle strobes: set or clear the write-enable latch, read status, write status, and start a program or erase at a given byte address. The unit also watches the board-level write-protect pin. It keeps the write-enable latch, a three-bit protection level, a status-lock bit and the busy flag, and returns the status byte while a status read is active.

A program or erase request is granted only when the latch is set, nothing is busy and the target address lies outside the region selected by the protection level. An accepted operation or status write raises busy for a number of clock cycles set by a parameter. When it finishes, busy drops and the write-enable latch clears itself. A status write is refused while the lock bit is set and the protect pin is low.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00: not busy, latch clear, protection level 0, lock bit clear.
- R2: While `cmd_rdsr` is high, `status_out` shows bit 7 lock, bits 6:5 zero, bits 4:2 protection level, bit 1 write-enable latch, bit 0 busy; while `cmd_rdsr` is low it reads 0x00.
- R3: `cmd_wren` sets the write-enable latch and `cmd_wrdi` clears it, visible from the next cycle; when both arrive together, the latch is cleared.
- R4: A status write while the latch is clear changes nothing.
- R5: While the lock bit is 1 and `wp_n` is low, a status write leaves the level, the lock bit and the latch unchanged and does not raise busy; with `wp_n` high the same write is accepted.
- R6: An accepted status write loads the level from `wrsr_bp` and the lock bit from `wrsr_lock` on the next cycle, holds busy for SRW_CYCLES cycles, then clears busy and the latch together.
- R7: An accepted program (`op_erase`=0) or erase (`op_erase`=1) pulses `op_grant` for one cycle and holds busy for PROG_CYCLES or ERASE_CYCLES cycles, both starting on the cycle after the request; at the end busy and the latch clear together.
- R8: With level k, the protected region is none for k=0, the whole array for k=7, and otherwise the top 1/2^(7-k) of the address space; a request inside it pulses `op_reject` for one cycle, does not raise busy and leaves the latch set.
- R9: While busy, every latch, status-write and start command is ignored.
- R10: A program or erase request with the latch clear is rejected with `op_reject` and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin level, low protects the status register when locked |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrdi | input | 1 | Clear write-enable latch strobe |
| cmd_rdsr | input | 1 | Status read active |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_bp | input | 3 | Protection level to write |
| wrsr_lock | input | 1 | Lock bit to write |
| op_start | input | 1 | Program or erase request strobe |
| op_erase | input | 1 | 1 selects erase timing, 0 program timing |
| op_addr | input | ADDR_W | Target byte address of the request |
| status_out | output | 8 | Status byte during a status read |
| busy | output | 1 | Operation or status write in progress |
| op_grant | output | 1 | One-cycle pulse for an accepted request |
| op_reject | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong latch or lock bit shows at the ports within one cycle: the next status read returns the wrong byte and the next request gets the opposite grant or reject pulse. A wrong protection decode flips a pulse the cycle after a request near a region boundary, so addresses just inside and just outside each boundary are driven. A busy counter that is off by one shows as busy and the latch falling a cycle early or late, which the per-cycle status comparison catches at the exact end cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [2:0] level;
    logic       wel;
    logic       wip;
  } fsr_stat_t;

  function automatic int unsigned fsr_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fsr_region_decode.sv
module fsr_region_decode #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic [2:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [6:1] above;

  for (genvar n = 1; n <= 6; n++) begin : g_base
    localparam logic [ADDR_W-1:0] BASE = {ADDR_W{1'b1}} << (ADDR_W - n);
    assign above[n] = (addr >= BASE);
  end

  always_comb begin
    case (level)
      3'd0:    hit = 1'b0;
      3'd7:    hit = 1'b1;
      default: hit = above[3'd7 - level];
    endcase
  end

endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 18,
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned ERASE_CYCLES = 24,
  parameter int unsigned SRW_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_rdsr,
  input  logic              cmd_wrsr,
  input  logic [2:0]        wrsr_bp,
  input  logic              wrsr_lock,
  input  logic              op_start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        status_out,
  output logic              busy,
  output logic              op_grant,
  output logic              op_reject
);

  localparam int unsigned MAX_CYC = fsr_max3(PROG_CYCLES, ERASE_CYCLES, SRW_CYCLES);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             wel_q, wel_d;
  logic [2:0]       bp_q, bp_d;
  logic             lock_q, lock_d;
  logic             grant_q, grant_d;
  logic             reject_q, reject_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             wip, wip_last;
  logic             in_region;
  logic             sr_locked;
  fsr_stat_t        stat;

  fsr_region_decode #(.ADDR_W(ADDR_W)) region_i (
    .level (bp_q),
    .addr  (op_addr),
    .hit   (in_region)
  );

  fsr_busy_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .busy     (wip),
    .last     (wip_last)
  );

  assign sr_locked = lock_q & ~wp_n;

  // Command arbitration: clear latch, set latch, status write, then request.
  always_comb begin
    wel_d    = wel_q;
    bp_d     = bp_q;
    lock_d   = lock_q;
    grant_d  = 1'b0;
    reject_d = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (wip) begin
      if (wip_last) wel_d = 1'b0;
    end else if (cmd_wrdi) begin
      wel_d = 1'b0;
    end else if (cmd_wren) begin
      wel_d = 1'b1;
    end else if (cmd_wrsr) begin
      if (wel_q && !sr_locked) begin
        bp_d     = wrsr_bp;
        lock_d   = wrsr_lock;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SRW_CYCLES);
      end
    end else if (op_start) begin
      if (wel_q && !in_region) begin
        tmr_load = 1'b1;
        tmr_val  = op_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
        grant_d  = 1'b1;
      end else begin
        reject_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      bp_q     <= 3'd0;
      lock_q   <= 1'b0;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      wel_q    <= wel_d;
      bp_q     <= bp_d;
      lock_q   <= lock_d;
      grant_q  <= grant_d;
      reject_q <= reject_d;
    end
  end

  always_comb begin
    stat.lock  = lock_q;
    stat.rsvd  = 2'b00;
    stat.level = bp_q;
    stat.wel   = wel_q;
    stat.wip   = wip;
  end

  assign status_out = cmd_rdsr ? stat : 8'h00;
  assign busy       = wip;
  assign op_grant   = grant_q;
  assign op_reject  = reject_q;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       cmd_wren,
  input logic       cmd_rdsr,
  input logic       cmd_wrsr,
  input logic [7:0] status_out,
  input logic       busy,
  input logic       op_grant,
  input logic       op_reject,
  input logic       wel_q,
  input logic [2:0] bp_q,
  input logic       lock_q
);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[6:5] == 2'b00);

  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdsr |-> status_out == 8'h00);

  assert_wel_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(cmd_wren));

  assert_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && lock_q && !wp_n) |=> ($stable(bp_q) && $stable(lock_q)));

  assert_wel_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel_q);

  assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_grant |-> busy);

  assert_reject_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |-> !busy);

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_reject));

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(bp_q) && $stable(lock_q)));

endmodule

bind flash_status_guard fsr_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_n       (wp_n),
  .cmd_wren   (cmd_wren),
  .cmd_rdsr   (cmd_rdsr),
  .cmd_wrsr   (cmd_wrsr),
  .status_out (status_out),
  .busy       (busy),
  .op_grant   (op_grant),
  .op_reject  (op_reject),
  .wel_q      (wel_q),
  .bp_q       (bp_q),
  .lock_q     (lock_q)
);

// File: tb/flash_status_guard_tb_top.sv
module flash_status_guard_tb_top;

  localparam int AW = 18;
  localparam int PC = 8;
  localparam int EC = 24;
  localparam int SC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_rdsr = 1'b0, cmd_wrsr = 1'b0;
  logic [2:0]    wrsr_bp = 3'd0;
  logic          wrsr_lock = 1'b0;
  logic          op_start = 1'b0, op_erase = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0]    status_out;
  logic          busy, op_grant, op_reject;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic       m_wel, m_lock, m_grant, m_reject;
  logic [2:0] m_bp;
  int         m_cnt;

  always #10 clk = ~clk;

  flash_status_guard #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .SRW_CYCLES(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr), .cmd_wrsr(cmd_wrsr),
    .wrsr_bp(wrsr_bp), .wrsr_lock(wrsr_lock),
    .op_start(op_start), .op_erase(op_erase), .op_addr(op_addr),
    .status_out(status_out), .busy(busy), .op_grant(op_grant), .op_reject(op_reject)
  );

  function automatic logic in_zone(input logic [2:0] k, input logic [AW-1:0] a);
    longint span, sz;
    span = longint'(1) << AW;
    if (k == 3'd0) return 1'b0;
    if (k == 3'd7) return 1'b1;
    sz = span >> (7 - int'(k));
    return longint'(a) >= span - sz;
  endfunction

  function automatic logic [7:0] exp_status(input logic rd);
    if (!rd) return 8'h00;
    return {m_lock, 2'b00, m_bp, m_wel, (m_cnt != 0)};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    m_grant  = 1'b0;
    m_reject = 1'b0;
    if (m_cnt != 0) begin
      if (m_cnt == 1) m_wel = 1'b0;
      m_cnt--;
    end else if (cmd_wrdi) begin
      m_wel = 1'b0;
    end else if (cmd_wren) begin
      m_wel = 1'b1;
    end else if (cmd_wrsr) begin
      if (m_wel && !(m_lock && !wp_n)) begin
        m_bp = wrsr_bp; m_lock = wrsr_lock; m_cnt = SC;
      end
    end else if (op_start) begin
      if (m_wel && !in_zone(m_bp, op_addr)) begin
        m_cnt = op_erase ? EC : PC; m_grant = 1'b1;
      end else begin
        m_reject = 1'b1;
      end
    end
  endtask

  // one cycle: drive at negedge, check after settling, advance model
  task automatic cyc(input string tag, input logic wren, input logic wrdi, input logic rd,
                     input logic wrsr, input logic [2:0] bp, input logic lk,
                     input logic st, input logic er, input logic [AW-1:0] a, input logic wp);
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_rdsr = rd; cmd_wrsr = wrsr;
    wrsr_bp = bp; wrsr_lock = lk; op_start = st; op_erase = er; op_addr = a; wp_n = wp;
    #1;
    chk(tag, "status", int'(status_out), int'(exp_status(rd)));
    chk(tag, "busy", int'(busy), int'(m_cnt != 0));
    chk(tag, "grant", int'(op_grant), int'(m_grant));
    chk(tag, "reject", int'(op_reject), int'(m_reject));
    model_step();
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 1, 0, 3'd0, 0, 0, 0, '0, wp_n);
  endtask

  task automatic wren(input string tag);
    cyc(tag, 1, 0, 1, 0, 3'd0, 0, 0, 0, '0, wp_n);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] top_addr;
    top_addr = '1;
    m_wel = 0; m_lock = 0; m_bp = 0; m_cnt = 0; m_grant = 0; m_reject = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    idle("R1", 2);
    // R2: read low gives zero
    cyc("R2", 0, 0, 0, 0, 3'd0, 0, 0, 0, '0, 1);
    // R4: status write without latch
    cyc("R4", 0, 0, 1, 1, 3'd5, 1, 0, 0, '0, 1);
    idle("R4", 2);
    // R10: request without latch
    cyc("R10", 0, 0, 1, 0, 3'd0, 0, 1, 0, 18'h00100, 1);
    idle("R10", 2);
    // R3: set, clear, simultaneous
    wren("R3"); idle("R3", 1);
    cyc("R3", 0, 1, 1, 0, 3'd0, 0, 0, 0, '0, 1); idle("R3", 1);
    wren("R3");
    cyc("R3", 1, 1, 1, 0, 3'd0, 0, 0, 0, '0, 1); idle("R3", 1);
    // R6: accepted write, level 1 and lock set
    wren("R6");
    cyc("R6", 0, 0, 1, 1, 3'd1, 1, 0, 0, '0, 1);
    // R9: commands during busy are ignored
    cyc("R9", 0, 1, 1, 0, 3'd0, 0, 0, 0, '0, 1);
    cyc("R9", 0, 0, 1, 1, 3'd7, 0, 0, 0, '0, 1);
    cyc("R9", 0, 0, 1, 0, 3'd0, 0, 1, 0, '0, 1);
    idle("R6", 3);
    // R5: locked with pin low refuses, pin high accepts
    wren("R5");
    cyc("R5", 0, 0, 1, 1, 3'd0, 0, 0, 0, '0, 0);
    idle("R5", 2);
    cyc("R5", 0, 0, 1, 1, 3'd1, 0, 0, 0, '0, 1);
    idle("R5", SC + 1);
    // R8: level 1 protects top 1/64
    wren("R8");
    cyc("R8", 0, 0, 1, 0, 3'd0, 0, 1, 0, top_addr, 1);
    idle("R8", 1);
    cyc("R8", 0, 0, 1, 0, 3'd0, 0, 1, 0, 18'h3EFFF, 1);
    // R7: program then erase timing
    idle("R7", PC + 1);
    wren("R7");
    cyc("R7", 0, 0, 1, 0, 3'd0, 0, 1, 1, 18'h00000, 1);
    idle("R7", EC + 1);
    // R8: level 7 protects all, level 6 upper half
    wren("R8"); cyc("R8", 0, 0, 1, 1, 3'd7, 0, 0, 0, '0, 1); idle("R8", SC + 1);
    wren("R8"); cyc("R8", 0, 0, 1, 0, 3'd0, 0, 1, 0, 18'h00000, 1); idle("R8", 1);
    cyc("R8", 0, 0, 1, 1, 3'd6, 0, 0, 0, '0, 1); idle("R8", SC + 1);
    wren("R8"); cyc("R8", 0, 0, 1, 0, 3'd0, 0, 1, 0, 18'h20000, 1); idle("R8", 1);
    cyc("R8", 0, 0, 1, 0, 3'd0, 0, 1, 0, 18'h1FFFF, 1); idle("R8", PC + 1);

    // random mix, fixed seed
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [AW-1:0] a;
      r = $urandom_range(99);
      a = ($urandom_range(1) == 1) ? AW'($urandom) : (top_addr - AW'($urandom_range(4095)));
      cyc("R9",
          r < 20,
          (r >= 20 && r < 24),
          $urandom_range(7) != 0,
          (r >= 24 && r < 36),
          3'($urandom),
          $urandom_range(2) == 0,
          (r >= 36 && r < 56),
          $urandom_range(1) == 1,
          a,
          $urandom_range(3) != 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule